// File: doc/BRIEF.md
# Prescaled Reload Down-Counter Timer

This block is a single-channel countdown timer that sits on a simple synchronous register bus. A 32-bit count register decreases by one on every prescaled tick. The tick is derived from the module clock by a prescaler that divides by 4, 16, 64 or 256. When a tick arrives while the count is zero, the count is refilled from a 32-bit constant register and a sticky underflow flag is raised. An interrupt request follows the flag when it is enabled.

Software sets the rate and the interrupt enable, starts or stops the count, and preloads or reads the count and the constant. With the constant and the count both at all ones and the interrupt disabled, the block works as a free-running time base. Elapsed ticks are then all ones minus the value read back.

Top module: `reload_down_timer`

## Requirements
- R1: After a synchronous active-low reset, the control and start registers read 0, the count and constant registers read 0xFFFFFFFF, and the interrupt request is low.
- R2: Control bits [2:0] pick the tick divider. Codes 0, 1, 2 and 3 give one tick every 4, 16, 64 and 256 clocks. Codes 4 to 7 behave as code 3.
- R3: Bit 0 of the start register (word address 1) runs the counter when 1. While it is 0 the count holds its value and the prescaler phase returns to zero.
- R4: The count register (word address 3) decreases by exactly one per tick. A software write loads it directly and takes precedence over a tick in the same cycle.
- R5: A tick that finds the count at 0 loads it from the constant register (word address 2) instead of wrapping, so one period spans constant+1 ticks.
- R6: Control bit 8 is the underflow flag. Hardware sets it on underflow and it stays set until a control write (word address 0) carries 0 in bit 8. Writing 1 there leaves the flag unchanged, and an underflow in the same cycle as a clear leaves it set.
- R7: The interrupt request is high exactly while control bit 5 (interrupt enable) and the underflow flag are both 1.
- R8: With both 32-bit registers at all ones, software reads the elapsed tick count as 0xFFFFFFFF minus the count value, read as a whole 32-bit word while the counter runs.
- R9: Reads return the addressed register in the same cycle. Control bits other than [2:0], 5 and 8 read as 0, and start bits other than bit 0 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Word address: 0 control, 1 start, 2 constant, 3 count |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, combinational |
| irq | output | 1 | Underflow interrupt request, level |

## Verification
The assertions assume that the bus inputs are known and stable through each rising edge. They also assume that at most one register is written per cycle, which the single address port guarantees. The bench changes inputs one time unit after the falling edge and compares results on the falling edge, so every write lands on exactly one rising edge. The stimulus deliberately drives the cases where the inputs meet inside the block's own timing: count writes that fall on a tick, flag clears that fall on an underflow, and divider changes while the counter runs.

// File: rtl/tmr_pkg.sv
// Package: shared constants, register word addresses and the prescaler
// limit function for the reload down-counter timer.
// Assumes: word-addressed register bus with a 2-bit address.
package tmr_pkg;

    localparam int CNT_W    = 32;
    localparam int SEL_W    = 3;
    localparam int MAX_CODE = 3;
    localparam int PRE_W    = 2 * MAX_CODE + 2;
    localparam int ADDR_W   = 2;
    localparam int IE_BIT   = 5;
    localparam int FLAG_BIT = 8;
    localparam int RUN_BIT  = 0;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 2'd0,
        REG_START = 2'd1,
        REG_CONST = 2'd2,
        REG_COUNT = 2'd3
    } reg_word_e;

    // Last phase value before a tick: divider 4 << (2*code), codes clamped.
    function automatic logic [PRE_W-1:0] tick_limit(input logic [SEL_W-1:0] code);
        int c;
        int lim;
        c   = (int'(code) > MAX_CODE) ? MAX_CODE : int'(code);
        lim = (4 << (2 * c)) - 1;
        return lim[PRE_W-1:0];
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
// Prescaler: counts module clocks and emits a one-cycle tick every
// 4^(code+1) clocks while run is high. The phase is held at zero while
// stopped. Assumes sel may change at any time; a phase already past the
// new limit ticks at once.
module tmr_prescaler #(
    parameter int SEL_W = tmr_pkg::SEL_W,
    parameter int PRE_W = tmr_pkg::PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [PRE_W-1:0] phase;
    logic [PRE_W-1:0] limit;

    // Limit for the selected divider.
    always_comb limit = tmr_pkg::tick_limit(sel);

    // Tick when the phase reaches the limit.
    always_comb tick = run && (phase >= limit);

    // Phase counter: cleared when stopped or after a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (!run || tick) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2

endmodule

// File: rtl/tmr_counter.sv
// Counter: 32-bit down counter with software preload and reload from the
// constant on underflow. Assumes tick is a one-cycle pulse and that a
// software load outranks a tick in the same cycle.
module tmr_counter #(
    parameter int CNT_W = tmr_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             underflow
);

    // Underflow: a tick that finds zero and is not overridden by a load.
    always_comb underflow = tick && !load_en && (count == '0);

    // Count update: load, reload or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '1;
        end else if (load_en) begin
            count <= load_val;
        end else if (underflow) begin
            count <= reload_val;
        end else if (tick) begin
            count <= count - 1'b1;
        end
    end

    AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_en && count != '0) |=> count == $past(count) - 1'b1); // R4
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_en && count == '0) |=> count == $past(reload_val)); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_en) |=> $stable(count)); // R3
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> count == $past(load_val)); // R4

endmodule

// File: rtl/tmr_regs.sv
// Register file: control (rate code, interrupt enable, underflow flag),
// start and constant registers. Assumes one write per cycle and a
// single-cycle underflow pulse from the counter.
module tmr_regs #(
    parameter int CNT_W  = tmr_pkg::CNT_W,
    parameter int SEL_W  = tmr_pkg::SEL_W,
    parameter int ADDR_W = tmr_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic              underflow,
    output logic [SEL_W-1:0]  sel,
    output logic              int_en,
    output logic              flag,
    output logic              run,
    output logic [CNT_W-1:0]  reload_val
);
    import tmr_pkg::*;

    logic ctrl_wr;
    logic start_wr;
    logic const_wr;
    logic flag_clr;

    // Write decode.
    always_comb begin
        ctrl_wr  = wr_en && (addr == REG_CTRL);
        start_wr = wr_en && (addr == REG_START);
        const_wr = wr_en && (addr == REG_CONST);
        flag_clr = ctrl_wr && !wdata[FLAG_BIT];
    end

    // Rate code and interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel    <= '0;
            int_en <= 1'b0;
        end else if (ctrl_wr) begin
            sel    <= wdata[SEL_W-1:0];
            int_en <= wdata[IE_BIT];
        end
    end

    // Underflow flag: set wins, cleared only by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (underflow) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end

    // Start bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
        end else if (start_wr) begin
            run <= wdata[RUN_BIT];
        end
    end

    // Constant register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_val <= '1;
        end else if (const_wr) begin
            reload_val <= wdata;
        end
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> flag); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(wr_en && addr == REG_CTRL && !wdata[FLAG_BIT])) |=> flag); // R6
    AST_FLAG_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !underflow) |=> !flag); // R6

endmodule

// File: rtl/reload_down_timer.sv
// Top: prescaled reload down-counter timer with a synchronous register
// bus and a level interrupt. Assumes the bus inputs are synchronous to
// clk; reads are combinational from the addressed register.
module reload_down_timer #(
    parameter int CNT_W  = tmr_pkg::CNT_W,
    parameter int SEL_W  = tmr_pkg::SEL_W,
    parameter int PRE_W  = tmr_pkg::PRE_W,
    parameter int ADDR_W = tmr_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);
    import tmr_pkg::*;

    logic             tick;
    logic             underflow;
    logic             run;
    logic             int_en;
    logic             flag;
    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] count;
    logic             count_wr;

    // Software preload strobe for the count register.
    always_comb count_wr = bus_wr && (bus_addr == REG_COUNT);

    tmr_prescaler #(.SEL_W(SEL_W), .PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .sel   (sel),
        .tick  (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load_en    (count_wr),
        .load_val   (bus_wdata),
        .reload_val (reload_val),
        .count      (count),
        .underflow  (underflow)
    );

    tmr_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .underflow  (underflow),
        .sel        (sel),
        .int_en     (int_en),
        .flag       (flag),
        .run        (run),
        .reload_val (reload_val)
    );

    // Interrupt request: enable and flag together.
    always_comb irq = int_en && flag;

    // Read mux: addressed register, unused bits zero.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            REG_CTRL: begin
                bus_rdata[SEL_W-1:0] = sel;
                bus_rdata[IE_BIT]    = int_en;
                bus_rdata[FLAG_BIT]  = flag;
            end
            REG_START: bus_rdata[RUN_BIT] = run;
            REG_CONST: bus_rdata = reload_val;
            REG_COUNT: bus_rdata = count;
            default:   bus_rdata = '0;
        endcase
    end

    AST_IRQ_ON_UNF: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && int_en && !(bus_wr && bus_addr == REG_CTRL)) |=> irq); // R7
    AST_IRQ_LOW_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_en && !(bus_wr && bus_addr == REG_CTRL)) |=> !irq); // R7
    AST_STOPPED_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !count_wr) |=> $stable(count)); // R3

endmodule

// File: tb/reload_down_timer_tb_top.sv
// Bench: behavioural reference model of the timer registers, compared
// with the design on every falling clock edge.
module reload_down_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd3;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    // Reference model state.
    bit [31:0] m_cnt, m_const;
    int        m_sel, m_phase;
    bit        m_ie, m_flag, m_run, m_valid;
    longint    m_ticks;

    always #4 clk = ~clk;   // 125 MHz

    reload_down_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit [31:0] model_read(input int a);
        case (a)
            0:       return {23'd0, m_flag, 2'd0, m_ie, 2'd0, 3'(m_sel)};
            1:       return {31'd0, m_run};
            2:       return m_const;
            default: return m_cnt;
        endcase
    endfunction

    // Reference model: one update per rising edge.
    always @(posedge clk) begin
        int  code, lim;
        bit  tk, uf;
        if (!rst_n) begin
            m_cnt = '1; m_const = '1; m_sel = 0; m_phase = 0;
            m_ie = 0; m_flag = 0; m_run = 0; m_valid = 1; m_ticks = 0;
        end else begin
            code = (m_sel > 3) ? 3 : m_sel;
            lim  = (4 << (2 * code)) - 1;
            tk   = m_run && (m_phase >= lim);
            uf   = 0;
            if (tk) m_ticks++;
            if (bus_wr && bus_addr == 2'd3) m_cnt = bus_wdata;
            else if (tk) begin
                if (m_cnt == 0) begin m_cnt = m_const; uf = 1; end
                else m_cnt = m_cnt - 1;
            end
            m_phase = (!m_run || tk) ? 0 : m_phase + 1;
            if (uf) m_flag = 1;
            else if (bus_wr && bus_addr == 2'd0 && !bus_wdata[8]) m_flag = 0;
            if (bus_wr && bus_addr == 2'd0) begin
                m_sel = int'(bus_wdata[2:0]);
                m_ie  = bus_wdata[5];
            end
            if (bus_wr && bus_addr == 2'd1) m_run = bus_wdata[0];
            if (bus_wr && bus_addr == 2'd2) m_const = bus_wdata;
        end
    end

    // Per-cycle comparison of the addressed register and the interrupt.
    always @(negedge clk) begin
        if (rst_n && m_valid && !done) begin
            case (bus_addr)
                2'd0:    chk("R6 control read", bus_rdata, model_read(0));
                2'd1:    chk("R3 start read", bus_rdata, model_read(1));
                2'd2:    chk("R5 constant read", bus_rdata, model_read(2));
                default: chk("R4 count read", bus_rdata, model_read(3));
            endcase
            chk("R7 irq", {31'd0, irq}, {31'd0, m_ie && m_flag});
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_wr = 1'b0; bus_addr = 2'd3;
    endtask

    task automatic peek(input logic [1:0] a);
        @(negedge clk); #1;
        bus_addr = a;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values.
        peek(2'd0); chk("R1 control reset", bus_rdata, 32'h0);
        peek(2'd1); chk("R1 start reset", bus_rdata, 32'h0);
        peek(2'd2); chk("R1 constant reset", bus_rdata, 32'hFFFF_FFFF);
        peek(2'd3); chk("R1 count reset", bus_rdata, 32'hFFFF_FFFF);
        chk("R1 irq reset", {31'd0, irq}, 32'h0);

        // R9: unused bits read zero.
        wr(2'd0, 32'hFFFF_FEDF);
        peek(2'd0); chk("R9 control unused bits", bus_rdata, 32'h0000_0007);
        wr(2'd0, 32'h0);
        wr(2'd1, 32'hFFFF_FFFE);
        peek(2'd1); chk("R9 start unused bits", bus_rdata, 32'h0);

        // R8: free running from all ones at divide-by-4.
        wr(2'd1, 32'h1);
        idle(100);
        peek(2'd3);
        chk("R8 elapsed ticks", 32'hFFFF_FFFF - bus_rdata, 32'(m_ticks));
        chk("R2 divide-by-4 tick count", 32'(m_ticks), 32'd25);

        // R3: stop holds the count.
        wr(2'd1, 32'h0);
        peek(2'd3);
        begin
            logic [31:0] held;
            held = bus_rdata;
            idle(50);
            peek(2'd3);
            chk("R3 count held while stopped", bus_rdata, held);
        end

        // R2: each rate code, including the clamped codes.
        for (int code = 0; code < 8; code += (code == 3 ? 3 : 1)) begin
            longint t0;
            wr(2'd3, 32'hFFFF_FFFF);
            wr(2'd0, 32'(code));
            t0 = m_ticks;
            wr(2'd1, 32'h1);
            idle(1023);
            wr(2'd1, 32'h0);
            peek(2'd3);
            chk($sformatf("R2 code %0d ticks", code), 32'hFFFF_FFFF - bus_rdata,
                32'((1024 + 1) / (4 << (2 * (code > 3 ? 3 : code)))));
            chk("R2 model agrees", 32'(m_ticks - t0), 32'hFFFF_FFFF - bus_rdata);
        end

        // R5, R6, R7: underflow, reload, flag and interrupt.
        wr(2'd0, 32'h20);
        wr(2'd2, 32'd9);
        wr(2'd3, 32'd2);
        wr(2'd1, 32'h1);
        idle(14);
        peek(2'd0);
        chk("R6 flag set after underflow", {31'd0, bus_rdata[8]}, 32'h1);
        chk("R7 irq with enable and flag", {31'd0, irq}, 32'h1);
        peek(2'd3);
        chk("R5 reloaded near constant", {31'd0, (bus_rdata <= 32'd9)}, 32'h1);
        wr(2'd0, 32'h0000_0120);
        peek(2'd0);
        chk("R6 write one keeps flag", {31'd0, bus_rdata[8]}, 32'h1);
        wr(2'd0, 32'h0);
        chk("R7 irq low without enable", {31'd0, irq}, 32'h0);
        wr(2'd1, 32'h0);
        wr(2'd0, 32'h0000_0020);
        peek(2'd0);
        chk("R6 write zero clears flag", {31'd0, bus_rdata[8]}, 32'h0);

        // R6: set and clear collide; constant 0 underflows every tick.
        wr(2'd2, 32'd0);
        wr(2'd3, 32'd0);
        wr(2'd1, 32'h1);
        for (int i = 0; i < 40; i++) wr(2'd0, 32'h0000_0020);
        peek(2'd0);
        chk("R6 flag after collisions", {31'd0, bus_rdata[8]}, {31'd0, m_flag});

        // R4: preloads landing on random cycles, some on ticks.
        wr(2'd2, 32'd50);
        for (int i = 0; i < 60; i++) begin
            wr(2'd3, 32'($urandom_range(0, 7)));
            idle(int'($urandom_range(0, 5)));
        end
        wr(2'd0, 32'h0000_0005);
        idle(600);
        peek(2'd3);
        chk("R4 count after preloads", bus_rdata, m_cnt);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule